// File: doc/BRIEF.md
# T1 Receive Channel Strobe Generator

This block derives the receive-side timing strobes of a T1 serial stream from the line bit clock. A bit counter walks the 193 positions of a frame: position 0 is the framing bit, and positions 1 to 192 carry channels 1 to 24 at eight bits each, most significant bit first. A frame counter walks the 12 frames of a multiframe. An external synchronizer pulses `resync` to align both counters to the framing bit of frame 1.

The block drives three registered outputs, each updated on the rising bit-clock edge. `chClk` marks the least significant bit of every channel. `syncOut` marks either every frame or only the multiframe start, and in frame mode it can be stretched to two bits on the signaling frames (frames 6 and 12). `chBlk` goes high for the whole of every channel whose bit is set in a 24-bit mask.

The mask and the two mode bits are loaded through a one-cycle write port. A write is held pending and takes effect only at the next frame boundary, so a channel is never partly blocked.

Top module: `t1_rx_strobe_gen`

## Requirements
- R1: A clock edge with `rstN` low drives all three outputs low, clears the mask and both mode bits (pending and active), and puts the counters on the framing bit of frame 1. The framing-bit cycle that follows release of reset shows no sync pulse.
- R2: `chClk` is high for exactly one cycle at bit positions 8, 16, ..., 192, which are the least significant bits of channels 1 to 24. It is low at every other position, including the framing bit. A frame is 193 cycles long.
- R3: With the multiframe mode bit at 0 and the double-wide bit at 0, `syncOut` is high only in the framing-bit cycle of every frame.
- R4: With the multiframe mode bit at 1, `syncOut` is high only in the framing-bit cycle of frame 1. Frame 12 is followed by frame 1. The double-wide bit has no effect in this mode.
- R5: With the multiframe mode bit at 0 and the double-wide bit at 1, `syncOut` is high for the framing bit and the next bit (position 1) of frames 6 and 12. It is high for the framing bit alone in every other frame.
- R6: Mask bit k-1 controls channel k. When that bit is 1, `chBlk` is high for all eight bit positions 8(k-1)+1 to 8k. `chBlk` is low at the framing bit and in every unmasked channel.
- R7: A clock edge with `resync` high puts the counters on the framing bit of frame 1 in the next cycle, whatever their previous position. The outputs in that cycle reflect that position.
- R8: A write (`wrEn` high) loads a pending copy of `wrMask`, `wrMultiMode` and `wrDblWide`. The pending copy becomes active at the next framing bit, reached either by wrap or by resync, and the latest write wins. A write issued in the last cycle before a framing bit waits one more frame.
- R9: A resync that arrives at bit 192 of frame 12, where the counters are already aligned, leaves the output sequence exactly as it would be without the resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Align counters to framing bit of frame 1 |
| wrEn | input | 1 | Load pending configuration |
| wrMask | input | 24 | Per-channel block mask, bit 0 = channel 1 |
| wrMultiMode | input | 1 | 1 = sync marks multiframe start only |
| wrDblWide | input | 1 | 1 = two-bit sync on signaling frames (frame mode) |
| chClk | output | 1 | High during LSB of each channel |
| syncOut | output | 1 | Frame or multiframe sync pulse |
| chBlk | output | 1 | High during masked channels |

## Verification
On every cycle, the assertions check four properties. The channel clock never lasts two cycles. The sync pulse never exceeds two cycles. Both `chClk` and `chBlk` stay low on the framing bit. The active configuration changes only when the counters enter a framing bit. They also check that a resync lands the counters on the first frame. The exact placement of each pulse within the frame and multiframe, the deferred update of the mask, and the glitch-free aligned resync can only be shown by the bench's scenarios, which compare every output on every cycle against an independent position model.

// File: rtl/t1RxPkg.sv
package t1RxPkg;
  localparam int CH_NUM     = 24;
  localparam int CH_W       = 8;
  localparam int MF_LEN     = 12;
  localparam int SIG_FRM_A  = 5;   // zero-based index of frame 6
  localparam int SIG_FRM_B  = 11;  // zero-based index of frame 12
  localparam int FRAME_BITS = 1 + CH_NUM * CH_W;
  localparam int BIT_CW     = $clog2(FRAME_BITS);
  localparam int CH_IW      = $clog2(CH_NUM);
  localparam int CH_SH      = $clog2(CH_W);
  localparam int FRM_IW     = $clog2(MF_LEN);

  typedef struct packed {
    logic              framing;
    logic              chanLsb;
    logic [CH_IW-1:0]  chan;
    logic              secondBit;
    logic              sigFrame;
    logic              mfStart;
  } slotStrobeT;

  typedef struct packed {
    logic [CH_NUM-1:0] mask;
    logic              multiMode;
    logic              dblWide;
  } cfgT;
endpackage

// File: rtl/t1RxCtrl.sv
module t1RxCtrl
  import t1RxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resync,
  input  logic              wrEn,
  input  logic [CH_NUM-1:0] wrMask,
  input  logic              wrMultiMode,
  input  logic              wrDblWide,
  output slotStrobeT        slotNext,
  output cfgT               cfgNext,
  output logic [BIT_CW-1:0] curBit
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_BITS - 1);
  localparam logic [FRM_IW-1:0] LAST_FRM = FRM_IW'(MF_LEN - 1);

  logic [BIT_CW-1:0] bitCnt, bitNext, offs;
  logic [FRM_IW-1:0] frmCnt, frmNext;
  cfgT pendCfg, actCfg;

  // next position in the frame / multiframe
  always_comb begin
    if (resync) begin
      bitNext = '0;
      frmNext = '0;
    end else if (bitCnt == LAST_BIT) begin
      bitNext = '0;
      frmNext = (frmCnt == LAST_FRM) ? '0 : frmCnt + 1'b1;
    end else begin
      bitNext = bitCnt + 1'b1;
      frmNext = frmCnt;
    end
  end

  // pending configuration becomes active on entry to a framing bit (R8)
  assign cfgNext = (bitNext == '0) ? pendCfg : actCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      frmCnt  <= '0;
      actCfg  <= '0;
      pendCfg <= '0;
    end else begin
      bitCnt <= bitNext;
      frmCnt <= frmNext;
      actCfg <= cfgNext;
      if (wrEn) pendCfg <= '{mask: wrMask, multiMode: wrMultiMode, dblWide: wrDblWide};
    end
  end

  // strobes describing the slot the counters are about to enter
  assign offs               = bitNext - 1'b1;
  assign slotNext.framing   = (bitNext == '0);
  assign slotNext.chanLsb   = (bitNext != '0) && (&offs[CH_SH-1:0]);
  assign slotNext.chan      = offs[CH_SH +: CH_IW];
  assign slotNext.secondBit = (bitNext == BIT_CW'(1));
  assign slotNext.sigFrame  = (frmNext == FRM_IW'(SIG_FRM_A)) || (frmNext == FRM_IW'(SIG_FRM_B));
  assign slotNext.mfStart   = (frmNext == '0);
  assign curBit             = bitCnt;

  a_r7_resync_aligns: assert property (@(posedge clk) disable iff (!rstN)
    resync |=> (bitCnt == '0) && (frmCnt == '0));
  a_r2_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == LAST_BIT && frmCnt == LAST_FRM && !resync) |=> (frmCnt == '0));
  a_r8_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != '0) |-> $stable(actCfg));
endmodule

// File: rtl/t1RxDatapath.sv
module t1RxDatapath
  import t1RxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  slotStrobeT slotNext,
  input  cfgT        cfgNext,
  output logic       chClk,
  output logic       syncOut,
  output logic       chBlk
);
  logic [CH_NUM-1:0] chanHit;
  logic blkNext, syncNext;

  for (genvar i = 0; i < CH_NUM; i++) begin : gChanDec
    assign chanHit[i] = (slotNext.chan == CH_IW'(i));
  end

  assign blkNext = !slotNext.framing && (|(chanHit & cfgNext.mask));

  always_comb begin
    if (cfgNext.multiMode)
      syncNext = slotNext.framing && slotNext.mfStart;
    else
      syncNext = slotNext.framing ||
                 (cfgNext.dblWide && slotNext.sigFrame && slotNext.secondBit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chClk   <= 1'b0;
      syncOut <= 1'b0;
      chBlk   <= 1'b0;
    end else begin
      chClk   <= slotNext.chanLsb;
      syncOut <= syncNext;
      chBlk   <= blkNext;
    end
  end

  a_r2_chclk_single: assert property (@(posedge clk) disable iff (!rstN)
    chClk |=> !chClk);
  a_r5_sync_max_two: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && $past(syncOut)) |=> !syncOut);
endmodule

// File: rtl/t1_rx_strobe_gen.sv
module t1_rx_strobe_gen
  import t1RxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              resync,
  input  logic              wrEn,
  input  logic [CH_NUM-1:0] wrMask,
  input  logic              wrMultiMode,
  input  logic              wrDblWide,
  output logic              chClk,
  output logic              syncOut,
  output logic              chBlk
);
  slotStrobeT        slotNext;
  cfgT               cfgNext;
  logic [BIT_CW-1:0] curBit;

  t1RxCtrl uCtrl (
    .clk(clk), .rstN(rstN), .resync(resync), .wrEn(wrEn), .wrMask(wrMask),
    .wrMultiMode(wrMultiMode), .wrDblWide(wrDblWide),
    .slotNext(slotNext), .cfgNext(cfgNext), .curBit(curBit)
  );

  t1RxDatapath uData (
    .clk(clk), .rstN(rstN), .slotNext(slotNext), .cfgNext(cfgNext),
    .chClk(chClk), .syncOut(syncOut), .chBlk(chBlk)
  );

  a_r6_quiet_framing: assert property (@(posedge clk) disable iff (!rstN)
    (curBit == '0) |-> (!chBlk && !chClk));
endmodule

// File: tb/t1_rx_strobe_gen_test.sv
module t1_rx_strobe_gen_test;
  logic clk = 1'b0, rstN = 1'b0, resync = 1'b0, wrEn = 1'b0;
  logic [23:0] wrMask = '0;
  logic wrMultiMode = 1'b0, wrDblWide = 1'b0;
  logic chClk, syncOut, chBlk;

  int vectors = 0, fails = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  t1_rx_strobe_gen uut (
    .clk(clk), .rstN(rstN), .resync(resync), .wrEn(wrEn), .wrMask(wrMask),
    .wrMultiMode(wrMultiMode), .wrDblWide(wrDblWide),
    .chClk(chClk), .syncOut(syncOut), .chBlk(chBlk)
  );

  // behavioural reference: position in frame and multiframe
  int mBit = 0, mFrm = 0;
  bit [23:0] pMask = '0, aMask = '0;
  bit pMulti = 0, aMulti = 0, pDbl = 0, aDbl = 0;
  bit eClk = 0, eSync = 0, eBlk = 0;
  bit inReset = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      mBit = 0; mFrm = 0; pMask = '0; aMask = '0;
      pMulti = 0; aMulti = 0; pDbl = 0; aDbl = 0;
      eClk = 0; eSync = 0; eBlk = 0; inReset = 1;
    end else begin
      int nb, nf;
      inReset = 0;
      if (resync) begin nb = 0; nf = 0; end
      else if (mBit == 192) begin nb = 0; nf = (mFrm == 11) ? 0 : mFrm + 1; end
      else begin nb = mBit + 1; nf = mFrm; end
      if (nb == 0) begin aMask = pMask; aMulti = pMulti; aDbl = pDbl; end
      if (wrEn) begin pMask = wrMask; pMulti = wrMultiMode; pDbl = wrDblWide; end
      mBit = nb; mFrm = nf;
      eClk = (mBit != 0) && (mBit % 8 == 0);
      eBlk = (mBit != 0) && aMask[(mBit - 1) / 8];
      if (aMulti) eSync = (mBit == 0) && (mFrm == 0);
      else eSync = (mBit == 0) || (aDbl && (mFrm == 5 || mFrm == 11) && mBit == 1);
    end
  end

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    string rq;
    vectors++;
    if (chClk !== eClk) begin
      fails++;
      $display("FAIL %s chClk (phase %s) bit=%0d frm=%0d actual=%b expected=%b",
               inReset ? "R1" : "R2", phase, mBit, mFrm + 1, chClk, eClk);
    end
    rq = inReset ? "R1" : aMulti ? "R4" : aDbl ? "R5" : "R3";
    if (syncOut !== eSync) begin
      fails++;
      $display("FAIL %s syncOut (phase %s) bit=%0d frm=%0d actual=%b expected=%b",
               rq, phase, mBit, mFrm + 1, syncOut, eSync);
    end
    if (chBlk !== eBlk) begin
      fails++;
      $display("FAIL %s chBlk (phase %s) bit=%0d frm=%0d actual=%b expected=%b",
               inReset ? "R1" : "R6", phase, mBit, mFrm + 1, chBlk, eBlk);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [23:0] m, input logic mm, input logic dw);
    wrEn = 1'b1; wrMask = m; wrMultiMode = mm; wrDblWide = dw;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPos(input int b, input int f);
    while (!(mBit == b && mFrm == f)) @(negedge clk);
  endtask

  task automatic pulseResync();
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
  endtask

  task automatic runAll();
    // R1: reset state, including a write attempted under reset
    phase = "R1";
    idle(3);
    wrEn = 1'b1; wrMask = 24'hFFFFFF; idle(1); wrEn = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(400);                      // R1/R2/R3: mask must be clear, frame sync only
    // R6 + R8: mask write mid-frame, applied at next boundary
    phase = "R8";
    waitPos(100, mFrm);
    writeCfg(24'h800F01, 1'b0, 1'b0);
    idle(600);
    // R8: latest of two writes wins, write at last bit waits a frame
    waitPos(192, mFrm);
    writeCfg(24'h00AA55, 1'b0, 1'b0);
    idle(50);
    writeCfg(24'h5500F0, 1'b0, 1'b0);
    idle(400);
    // R7: resync from mid-frame
    phase = "R7";
    waitPos(57, mFrm);
    pulseResync();
    idle(300);
    pulseResync();
    pulseResync();
    idle(200);
    // R5: double-wide sync on signaling frames
    phase = "R5";
    writeCfg(24'h0F0F0F, 1'b0, 1'b1);
    idle(13 * 193);
    // R9: aligned resync at the end of frame 12
    phase = "R9";
    waitPos(192, 11);
    pulseResync();
    idle(2 * 193);
    // R4: multiframe mode, double-wide set but ignored
    phase = "R4";
    writeCfg(24'hFFFFFF, 1'b1, 1'b1);
    idle(25 * 193);
    // R9 in multiframe mode
    phase = "R9";
    waitPos(192, 11);
    pulseResync();
    idle(400);
    // R3: back to frame mode, single width, all channels unmasked
    phase = "R3";
    writeCfg(24'h000000, 1'b0, 1'b0);
    idle(3 * 193);
    // R1: reset in mid-stream clears everything
    phase = "R1";
    waitPos(77, mFrm);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(500);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule